// File: doc/BRIEF.md
# PLL Coefficient Search Engine

This block takes a requested output frequency and a reference frequency, both in kHz. It searches for a reference divider M, a feedback multiplier N and a post-divider index PL for a clock synthesizer. It walks through the candidates one at a time. It uses one shared multi-cycle restoring divider, so the search takes many clock cycles. While it runs it keeps the candidate whose achieved output frequency lies closest to the request.

A search is started with a single-cycle pulse on `start_i`. The frequency inputs and the limit inputs are captured at that moment. `busy_o` stays high while the search runs. When it finishes, `done_o` pulses for one cycle and the result outputs change in that same cycle. The results are the chosen M, N and PL, the achieved rate, and a flag that tells whether any candidate met the limits. The caller must keep `min_m_i` at 1 or more, and must keep `ref_i` and `rate_i` above zero.

Top module: `pll_coef_search`

## Requirements
- R1: While reset is asserted, and after it is released with no search yet started, `busy_o`, `done_o` and `found_o` are 0 and `m_o`, `n_o`, `pl_o` and `rate_o` are 0.
- R2: A `start_i` pulse while idle makes `busy_o` high in the next cycle. `done_o` is high for exactly one cycle, with `busy_o` low in that cycle. A `start_i` raised while busy is ignored: it changes neither the running search nor its results, and no second search follows.
- R3: The VCO target is T + floor(T/50), where T = 2·rate. The effective VCO ceiling is the larger of `max_vco_i` and this target.
- R4: The PL indices tried run upward from `min_pl_i` to the smallest of floor((ceiling + target − 1)/target), `max_pl_i` and 14. If `min_pl_i` exceeds that bound, no index is tried.
- R5: PL index k selects the post-divide ratio at position k of 1, 2, 3, 4, 5, 6, 8, 10, 12, 16, 12, 16, 20, 24, 32. An index above 14 selects 32.
- R6: The achieved rate of a candidate is floor(ref·N / (2·M·ratio)). Its error is the absolute difference from `rate_i`.
- R7: For each PL, M runs upward from `min_m_i` to `max_m_i`. The M loop for that PL ends at the first M where ref < `min_u_i`·M.
- R8: For each (PL, M) the N candidates are n0 = floor(2·rate·ratio·M / ref) and then n0+1. A candidate above `max_n_i` ends the N loop. A candidate below `min_n_i` is skipped. A candidate whose floor(ref·N/M) lies outside [`min_vco_i`, effective ceiling] is also skipped.
- R9: The order is PL outer, M middle, N inner. The result is the candidate with the smallest error. Among equal errors the first one found is kept. A candidate with zero error ends the search at once.
- R10: If no candidate qualifies, `found_o` is 0 and the outputs are M = `max_m_i`, N = `min_n_i`, PL = `min_pl_i`. `rate_o` then holds the achieved rate of that triple.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a search (ignored while busy) |
| rate_i | input | FW | Requested output frequency, kHz |
| ref_i | input | FW | Reference frequency, kHz |
| min_m_i | input | MW | Smallest M |
| max_m_i | input | MW | Largest M |
| min_n_i | input | NW | Smallest N |
| max_n_i | input | NW | Largest N |
| min_pl_i | input | PW | Smallest PL index |
| max_pl_i | input | PW | Largest PL index |
| min_u_i | input | FW | Minimum comparison frequency ref/M, kHz |
| min_vco_i | input | FW | Minimum VCO frequency, kHz |
| max_vco_i | input | FW | Configured maximum VCO frequency, kHz |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle pulse when results are updated |
| found_o | output | 1 | A qualifying candidate was found |
| m_o | output | MW | Chosen M |
| n_o | output | NW | Chosen N |
| pl_o | output | PW | Chosen PL index |
| rate_o | output | FW | Achieved output rate, kHz |

## Verification
Some behaviours are checked by assertions on every cycle:
- the start/busy/done handshake;
- that the divider's quotient and remainder rebuild its dividend;
- that the best error never grows within a search;
- that a reported match has its N and PL inside the limits;
- that a no-match report carries the default triple.

Other behaviours only the bench scenarios can show:
- which candidate wins: the tie rule, the early stop on an exact match, the M cutoff, the raised VCO ceiling and the table lookup;
- the achieved rate.

For these, a bench model walks the same ordered search and the outputs are compared with its results.

// File: rtl/pll_srch_pkg.sv
package pll_srch_pkg;
  localparam int unsigned PL_TOP = 14;

  typedef enum logic [3:0] {
    S_IDLE, S_PLHI, S_MSTART, S_NDIV, S_NCHK, S_RDIV, S_ADV, S_NEXTPL, S_FIN, S_DDIV
  } srch_st_e;

  // post-divide ratio per PL index; non-monotonic above index 9
  function automatic logic [5:0] pl_ratio(input int unsigned idx);
    case (idx)
      0: pl_ratio = 6'd1;   1: pl_ratio = 6'd2;   2: pl_ratio = 6'd3;
      3: pl_ratio = 6'd4;   4: pl_ratio = 6'd5;   5: pl_ratio = 6'd6;
      6: pl_ratio = 6'd8;   7: pl_ratio = 6'd10;  8: pl_ratio = 6'd12;
      9: pl_ratio = 6'd16;  10: pl_ratio = 6'd12; 11: pl_ratio = 6'd16;
      12: pl_ratio = 6'd20; 13: pl_ratio = 6'd24;
      default: pl_ratio = 6'd32;
    endcase
  endfunction
endpackage

// File: rtl/pll_srch_div.sv
module pll_srch_div #(
  parameter int DW = 37
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] num_i,
  input  logic [DW-1:0] den_i,
  output logic          done_o,
  output logic [DW-1:0] quo_o
);
  localparam int CW = $clog2(DW + 1);

  logic [DW-1:0] quo_q, den_q, num_q;
  logic [DW:0]   rem_q, rem_sh;
  logic [CW-1:0] cnt_q;
  logic          run_q, done_q, take;

  assign rem_sh = {rem_q[DW-1:0], quo_q[DW-1]};
  assign take   = rem_sh >= {1'b0, den_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quo_q  <= '0;
      den_q  <= '0;
      num_q  <= '0;
      rem_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !run_q) begin
        quo_q <= num_i;
        num_q <= num_i;
        den_q <= den_i;
        rem_q <= '0;
        cnt_q <= CW'(DW);
        run_q <= 1'b1;
      end else if (run_q) begin
        rem_q <= take ? rem_sh - {1'b0, den_q} : rem_sh;
        quo_q <= {quo_q[DW-2:0], take};
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign quo_o  = quo_q;

  // R6: quotient and remainder reconstruct the latched dividend
  p_div_exact_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && den_q != '0) |->
      ((2*DW)'(quo_q) * (2*DW)'(den_q) + (2*DW)'(rem_q) == (2*DW)'(num_q))
      && (rem_q < {1'b0, den_q}));
endmodule

// File: rtl/pll_srch_best.sv
module pll_srch_best #(
  parameter int MW = 8,
  parameter int NW = 8,
  parameter int PW = 4,
  parameter int FW = 22,
  parameter int DW = 37
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          upd_i,
  input  logic [MW-1:0] m_i,
  input  logic [NW-1:0] n_i,
  input  logic [PW-1:0] pl_i,
  input  logic [FW-1:0] rate_i,
  input  logic [DW-1:0] err_i,
  output logic          found_o,
  output logic [MW-1:0] m_o,
  output logic [NW-1:0] n_o,
  output logic [PW-1:0] pl_o,
  output logic [FW-1:0] rate_o
);
  logic          found_q;
  logic [DW-1:0] err_q;
  logic          take;

  // strict compare keeps the earliest of equal errors
  assign take = upd_i && (!found_q || err_i < err_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      found_q <= 1'b0;
      err_q   <= '0;
      m_o     <= '0;
      n_o     <= '0;
      pl_o    <= '0;
      rate_o  <= '0;
    end else if (clr_i) begin
      found_q <= 1'b0;
      err_q   <= '0;
    end else if (take) begin
      found_q <= 1'b1;
      err_q   <= err_i;
      m_o     <= m_i;
      n_o     <= n_i;
      pl_o    <= pl_i;
      rate_o  <= rate_i;
    end
  end

  assign found_o = found_q;

  // R9: best error never grows within one search
  p_err_mono_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (found_q && !clr_i) |=> (err_q <= $past(err_q)));
endmodule

// File: rtl/pll_coef_search.sv
module pll_coef_search
  import pll_srch_pkg::*;
#(
  parameter int FW = 22,
  parameter int MW = 8,
  parameter int NW = 8,
  parameter int PW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [FW-1:0] rate_i,
  input  logic [FW-1:0] ref_i,
  input  logic [MW-1:0] min_m_i,
  input  logic [MW-1:0] max_m_i,
  input  logic [NW-1:0] min_n_i,
  input  logic [NW-1:0] max_n_i,
  input  logic [PW-1:0] min_pl_i,
  input  logic [PW-1:0] max_pl_i,
  input  logic [FW-1:0] min_u_i,
  input  logic [FW-1:0] min_vco_i,
  input  logic [FW-1:0] max_vco_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          found_o,
  output logic [MW-1:0] m_o,
  output logic [NW-1:0] n_o,
  output logic [PW-1:0] pl_o,
  output logic [FW-1:0] rate_o
);
  localparam int DW = FW + MW + 7;

  srch_st_e      st_q;
  logic [FW-1:0] rate_q, ref_q, min_u_q, min_vco_q;
  logic [MW-1:0] min_m_q, max_m_q;
  logic [NW-1:0] min_n_q, max_n_q;
  logic [PW-1:0] min_pl_q, max_pl_q, plhi_q, pl_q;
  logic [DW-1:0] vmax_q, n_q;
  logic [MW:0]   m_q;
  logic          nc_q;

  logic          div_go, div_done;
  logic [DW-1:0] div_num, div_den, quo;
  logic          best_found, best_upd, best_clr;
  logic [MW-1:0] best_m;
  logic [NW-1:0] best_n;
  logic [PW-1:0] best_pl;
  logic [FW-1:0] best_rate;

  logic [DW-1:0] t2, tv, vmx, div_pl, m_ext, ref_ext, refn, err, pl_lim, hi_c;
  logic          u_low, vco_ok, m_ok;

  assign t2      = DW'(rate_i) << 1;
  assign tv      = t2 + t2 / DW'(50);
  assign vmx     = (DW'(max_vco_i) > tv) ? DW'(max_vco_i) : tv;
  assign div_pl  = DW'(pl_ratio(32'(pl_q)));
  assign m_ext   = DW'(m_q);
  assign ref_ext = DW'(ref_q);
  assign refn    = ref_ext * n_q;
  assign u_low   = ref_ext < DW'(min_u_q) * m_ext;
  assign m_ok    = (m_q <= (MW+1)'(max_m_q)) && !u_low;
  assign vco_ok  = (refn >= DW'(min_vco_q) * m_ext) && (refn < (vmax_q + DW'(1)) * m_ext);
  assign err     = (quo >= DW'(rate_q)) ? quo - DW'(rate_q) : DW'(rate_q) - quo;
  assign pl_lim  = (DW'(max_pl_q) < DW'(PL_TOP)) ? DW'(max_pl_q) : DW'(PL_TOP);
  assign hi_c    = (quo < pl_lim) ? quo : pl_lim;

  always_comb begin
    div_go  = 1'b0;
    div_num = '0;
    div_den = '0;
    case (st_q)
      S_IDLE: if (start_i) begin
        div_go = 1'b1; div_num = vmx + tv - DW'(1); div_den = tv;
      end
      S_MSTART: if (m_ok) begin
        div_go = 1'b1; div_num = ((DW'(rate_q) << 1) * div_pl) * m_ext; div_den = ref_ext;
      end
      S_NCHK: if (n_q <= DW'(max_n_q) && n_q >= DW'(min_n_q) && vco_ok) begin
        div_go = 1'b1; div_num = refn; div_den = (m_ext << 1) * div_pl;
      end
      S_FIN: if (!best_found) begin
        div_go  = 1'b1;
        div_num = ref_ext * DW'(min_n_q);
        div_den = (DW'(max_m_q) << 1) * DW'(pl_ratio(32'(min_pl_q)));
      end
      default: ;
    endcase
  end

  assign best_clr = (st_q == S_IDLE) && start_i;
  assign best_upd = (st_q == S_RDIV) && div_done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE;
      {rate_q, ref_q, min_u_q, min_vco_q} <= '0;
      {min_m_q, max_m_q, min_n_q, max_n_q} <= '0;
      {min_pl_q, max_pl_q, plhi_q, pl_q} <= '0;
      vmax_q <= '0; n_q <= '0; m_q <= '0; nc_q <= 1'b0;
      done_o <= 1'b0; found_o <= 1'b0;
      m_o <= '0; n_o <= '0; pl_o <= '0; rate_o <= '0;
    end else begin
      done_o <= 1'b0;
      case (st_q)
        S_IDLE: if (start_i) begin
          rate_q <= rate_i; ref_q <= ref_i; min_u_q <= min_u_i; min_vco_q <= min_vco_i;
          min_m_q <= min_m_i; max_m_q <= max_m_i; min_n_q <= min_n_i; max_n_q <= max_n_i;
          min_pl_q <= min_pl_i; max_pl_q <= max_pl_i;
          vmax_q <= vmx;
          st_q <= S_PLHI;
        end
        S_PLHI: if (div_done) begin
          plhi_q <= PW'(hi_c);
          pl_q   <= min_pl_q;
          m_q    <= (MW+1)'(min_m_q);
          st_q   <= (DW'(min_pl_q) > hi_c) ? S_FIN : S_MSTART;
        end
        S_MSTART: st_q <= m_ok ? S_NDIV : S_NEXTPL;
        S_NDIV: if (div_done) begin
          n_q <= quo; nc_q <= 1'b0; st_q <= S_NCHK;
        end
        S_NCHK: begin
          if (n_q > DW'(max_n_q)) begin
            m_q <= m_q + 1'b1; st_q <= S_MSTART;
          end else st_q <= div_go ? S_RDIV : S_ADV;
        end
        S_RDIV: if (div_done) st_q <= (err == '0) ? S_FIN : S_ADV;
        S_ADV: begin
          if (!nc_q) begin
            n_q <= n_q + DW'(1); nc_q <= 1'b1; st_q <= S_NCHK;
          end else begin
            m_q <= m_q + 1'b1; st_q <= S_MSTART;
          end
        end
        S_NEXTPL: begin
          if (pl_q >= plhi_q) st_q <= S_FIN;
          else begin
            pl_q <= pl_q + 1'b1; m_q <= (MW+1)'(min_m_q); st_q <= S_MSTART;
          end
        end
        S_FIN: begin
          if (best_found) begin
            m_o <= best_m; n_o <= best_n; pl_o <= best_pl; rate_o <= best_rate;
            found_o <= 1'b1; done_o <= 1'b1; st_q <= S_IDLE;
          end else st_q <= S_DDIV;
        end
        S_DDIV: if (div_done) begin
          m_o <= max_m_q; n_o <= min_n_q; pl_o <= min_pl_q; rate_o <= quo[FW-1:0];
          found_o <= 1'b0; done_o <= 1'b1; st_q <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q != S_IDLE);

  pll_srch_div #(.DW(DW)) u_div (
    .clk_i, .rst_ni, .start_i(div_go), .num_i(div_num), .den_i(div_den),
    .done_o(div_done), .quo_o(quo)
  );

  pll_srch_best #(.MW(MW), .NW(NW), .PW(PW), .FW(FW), .DW(DW)) u_best (
    .clk_i, .rst_ni, .clr_i(best_clr), .upd_i(best_upd),
    .m_i(m_q[MW-1:0]), .n_i(n_q[NW-1:0]), .pl_i(pl_q), .rate_i(quo[FW-1:0]), .err_i(err),
    .found_o(best_found), .m_o(best_m), .n_o(best_n), .pl_o(best_pl), .rate_o(best_rate)
  );

  p_start_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
  p_done_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  p_pl_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && found_o) |-> (pl_o >= min_pl_q && pl_o <= max_pl_q && pl_o <= PW'(PL_TOP)));
  p_n_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && found_o) |-> (n_o >= min_n_q && n_o <= max_n_q));
  p_nomatch_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !found_o) |-> (m_o == max_m_q && n_o == min_n_q && pl_o == min_pl_q));
endmodule

// File: tb/sim_pll_coef_search.sv
module sim_pll_coef_search;
  localparam int FW = 22, MW = 8, NW = 8, PW = 4;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [FW-1:0] rate_i = '0, ref_i = '0, min_u = '0, min_vco = '0, max_vco = '0;
  logic [MW-1:0] min_m = '0, max_m = '0;
  logic [NW-1:0] min_n = '0, max_n = '0;
  logic [PW-1:0] min_pl = '0, max_pl = '0;
  logic busy, done, found;
  logic [MW-1:0] m_o;
  logic [NW-1:0] n_o;
  logic [PW-1:0] pl_o;
  logic [FW-1:0] r_o;
  int total = 0, fails = 0;

  always #4 clk = ~clk;

  pll_coef_search #(.FW(FW), .MW(MW), .NW(NW), .PW(PW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .rate_i(rate_i), .ref_i(ref_i),
    .min_m_i(min_m), .max_m_i(max_m), .min_n_i(min_n), .max_n_i(max_n),
    .min_pl_i(min_pl), .max_pl_i(max_pl), .min_u_i(min_u), .min_vco_i(min_vco),
    .max_vco_i(max_vco), .busy_o(busy), .done_o(done), .found_o(found),
    .m_o(m_o), .n_o(n_o), .pl_o(pl_o), .rate_o(r_o));

  task automatic check(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint ratio(input longint k);
    longint t[15] = '{1, 2, 3, 4, 5, 6, 8, 10, 12, 16, 12, 16, 20, 24, 32};
    return (k > 14) ? 32 : t[k];
  endfunction

  // ordered search written from the requirements
  task automatic model(input longint rate, rf, mnm, mxm, mnn, mxn, mnp, mxp, mnu, mnv, mxv,
                       output longint em, en, ep, er, output bit ef);
    longint t2, tv, vmax, hi, be, d, n0, n, r, e;
    bit stop;
    t2 = 2 * rate; tv = t2 + t2 / 50;
    vmax = (mxv > tv) ? mxv : tv;
    hi = (vmax + tv - 1) / tv;
    if (hi > mxp) hi = mxp;
    if (hi > 14) hi = 14;
    stop = 0; ef = 0; be = 0; em = 0; en = 0; ep = 0; er = 0;
    for (longint pl = mnp; pl <= hi && !stop; pl++) begin
      d = ratio(pl);
      for (longint m = mnm; m <= mxm && !stop; m++) begin
        if (rf < mnu * m) break;
        n0 = (t2 * d * m) / rf;
        for (int k = 0; k < 2 && !stop; k++) begin
          n = n0 + k;
          if (n > mxn) break;
          if (n < mnn) continue;
          if (rf * n < mnv * m || rf * n >= (vmax + 1) * m) continue;
          r = (rf * n) / (2 * m * d);
          e = (r > rate) ? r - rate : rate - r;
          if (!ef || e < be) begin ef = 1; be = e; em = m; en = n; ep = pl; er = r; end
          if (e == 0) stop = 1;
        end
      end
    end
    if (!ef) begin
      em = mxm; en = mnn; ep = mnp; er = (rf * mnn) / (2 * mxm * ratio(mnp));
    end
  endtask

  task automatic run(input string tag, input longint rate, rf, mnm, mxm, mnn, mxn,
                     mnp, mxp, mnu, mnv, mxv, input bit poke,
                     output bit ef_o, output longint ep_o);
    longint em, en, ep, er;
    bit ef;
    int cyc;
    model(rate, rf, mnm, mxm, mnn, mxn, mnp, mxp, mnu, mnv, mxv, em, en, ep, er, ef);
    @(negedge clk);
    rate_i = FW'(rate); ref_i = FW'(rf); min_m = MW'(mnm); max_m = MW'(mxm);
    min_n = NW'(mnn); max_n = NW'(mxn); min_pl = PW'(mnp); max_pl = PW'(mxp);
    min_u = FW'(mnu); min_vco = FW'(mnv); max_vco = FW'(mxv);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check({tag, " R2 busy after start"}, busy, 1);
    if (poke) begin
      repeat (5) @(negedge clk);
      rate_i = FW'(rate + 777); start = 1'b1;
      @(negedge clk);
      start = 1'b0; rate_i = FW'(rate);
    end
    cyc = 0;
    while (!done && cyc < 40000) begin @(negedge clk); cyc++; end
    check({tag, " R2 done reached"}, done, 1);
    check({tag, " R2 busy low at done"}, busy, 0);
    check({tag, " found"}, found, ef);
    check({tag, " m"}, m_o, em);
    check({tag, " n"}, n_o, en);
    check({tag, " pl"}, pl_o, ep);
    check({tag, " rate"}, r_o, er & ((64'd1 << FW) - 1));
    @(negedge clk);
    check({tag, " R2 done one cycle"}, done, 0);
    ef_o = ef; ep_o = ep;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL R2 watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    bit ef;
    longint ep, rf;
    longint refs[5] = '{12000, 12800, 13000, 19200, 38400};
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    check("R1 busy in reset", busy, 0);
    check("R1 done in reset", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 found after reset", found, 0);
    check("R1 outputs after reset", {m_o, n_o, pl_o, r_o}, 0);

    // exact hit stops search, first candidate kept
    run("R9 exact", 300000, 12000, 1, 4, 50, 150, 0, 3, 1000, 100000, 3000000, 0, ef, ep);
    check("R9 exact found", ef, 1);
    // ceiling raised above tiny max_vco, PL bound collapses to 1
    run("R3 raise", 1000000, 12000, 1, 2, 1, 255, 0, 5, 1000, 1000, 1000, 0, ef, ep);
    check("R3 found with raised ceiling", found, 1);
    check("R4 pl bound", pl_o <= 1, 1);
    // forced high table index
    run("R5 table", 40000, 13000, 1, 3, 10, 255, 10, 10, 1000, 100000, 3000000, 0, ef, ep);
    run("R5 table top", 30000, 19200, 1, 3, 10, 255, 13, 14, 1000, 100000, 3000000, 0, ef, ep);
    // empty N window: defaults
    run("R8 R10 nomatch", 300000, 12000, 2, 5, 200, 100, 1, 4, 1000, 100000, 3000000, 0, ef, ep);
    check("R10 found low", found, 0);
    // comparison frequency cuts every M
    run("R7 ucut", 300000, 12000, 1, 4, 10, 255, 0, 4, 20000, 100000, 3000000, 0, ef, ep);
    check("R7 no match from cutoff", found, 0);
    run("R7 partial", 250000, 38400, 1, 6, 10, 255, 0, 3, 9000, 100000, 3000000, 0, ef, ep);
    // min_pl above bound
    run("R4 empty pl", 900000, 12000, 1, 2, 1, 255, 9, 12, 1000, 100000, 1900000, 0, ef, ep);
    check("R4 empty range no match", found, 0);
    // start while busy ignored
    run("R2 poke", 333000, 12800, 1, 3, 20, 255, 0, 4, 3000, 1000000, 2600000, 1, ef, ep);
    repeat (3) @(negedge clk);
    check("R2 no second search", busy, 0);

    for (int i = 0; i < 24; i++) begin
      longint mnm, mnn, mnp;
      rf  = refs[$urandom % 5];
      mnm = 1 + $urandom % 2;
      mnn = 20 + $urandom % 40;
      mnp = $urandom % 3;
      run("R6 R9 random", 50000 + $urandom % 600000, rf, mnm, mnm + $urandom % 3,
          mnn, mnn + $urandom % (256 - mnn), mnp, mnp + $urandom % 4,
          5000 + $urandom % 8000, 1000000 + $urandom % 300000,
          1800000 + $urandom % 800000, 0, ef, ep);
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule